// File: doc/BRIEF.md
# Software Lock Arbiter for a Shared Non-Volatile Memory Port

This block is a memory-mapped semaphore. Four software agents compete through it for exclusive use of one non-volatile memory port. Each agent asks for the lock and gives it back by writing single-bit strobes into one 32-bit arbitration word. Ones written to the low byte set or clear request flags. The same word reads back the request and grant flags. A fixed priority picks one owner, with agent 0 first. The owner keeps the lock until it clears its own request, even if a higher-priority agent asks later.

A second, small access-control word sits next to the arbitration word. One bit of it gates writes to every other register of the memory interface. The arbitration word and the access-control word itself are always writable. A second bit overrides the global write-enable mode bit, so that memory write commands can be issued while that mode bit is 0. The block drives a one-hot grant vector, a write-permit level and a gated write strobe for the other registers, all for the downstream memory controller.

Top module: `mem_lock_arb`

## Requirements
- R1: A write to the arbitration word (address 0) sets request n for each bit n of bits 3:0 that is 1. A write of all zeros changes nothing.
- R2: A write to the arbitration word clears request n for each bit 4+n of bits 7:4 that is 1.
- R3: Reading the arbitration word returns the grant flags in bits 11:8 and the request flags in bits 15:12. All other bits read 0. Every flag is 0 after reset.
- R4: At most one grant flag, and at most one bit of the grant output, is 1 at any time.
- R5: When the lock is free, the lowest-numbered pending request gets it.
- R6: A granted agent keeps the grant until its own clear strobe is written. New requests from higher-priority agents do not take it away.
- R7: In the cycle after the write that clears the owner, the grant moves to the highest-priority request still pending. If none is pending, no grant is held.
- R8: If the set strobe and the clear strobe for the same request are both 1 in one write, the request ends up cleared.
- R9: Bit 0 of the access-control word (address 1, reset 0) gates writes to other addresses. The gated write output is 1 during such a write only while this bit is 1. Writes to the arbitration word work whatever its value.
- R10: The write-permit output equals the global write-enable input OR bit 1 of the access-control word (reset 0).
- R11: Reading the access-control word returns its two bits in bits 1:0 and 0 elsewhere. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe for the current address |
| busAddr | input | ADDR_W (4) | Word address: 0 arbitration word, 1 access-control word, others belong to the memory interface |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address (combinational) |
| globalWrEn | input | 1 | Global write-enable mode bit from the memory controller |
| grantOneHot | output | AGENTS (4) | One-hot owner of the lock |
| writePermit | output | 1 | A memory write command may be issued |
| extRegWrite | output | 1 | Gated write strobe for the other memory-interface registers |

## Verification
A request flag that is wrongly stored shows up as a bad bit in bits 15:12 of the readback. The grant then goes to the wrong owner or moves at the wrong time, which the grant output shows in the cycle after the write that caused it. An access-control bit that is wrong shows at once on writePermit, and on extRegWrite during the next write to another address. The bench keeps its own model of the requests, the owner and the access bits, and compares every output on every cycle. With one output compare per cycle, any divergence is reported within one clock of the write that causes it.

// File: rtl/mlk_pkg.sv
package mlk_pkg;
  localparam int MAX_AGENTS = 8;

  typedef enum logic [1:0] {RD_NONE, RD_ARB, RD_ACC} readSel_t;

  typedef struct packed {
    logic [MAX_AGENTS-1:0] setMask;
    logic [MAX_AGENTS-1:0] clrMask;
    logic                  accWr;
    logic [1:0]            accData;
    logic                  extWr;
    readSel_t              readSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/mlk_ctrl.sv
module mlk_ctrl
  import mlk_pkg::*;
#(
  parameter int AGENTS   = 4,
  parameter int ADDR_W   = 4,
  parameter int ARB_ADDR = 0,
  parameter int ACC_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              accEn,
  output ctrlStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] ArbA = ADDR_W'(ARB_ADDR);
  localparam logic [ADDR_W-1:0] AccA = ADDR_W'(ACC_ADDR);

  logic isArb, isAcc;
  logic unusedWdata;

  assign isArb = (busAddr == ArbA);
  assign isAcc = (busAddr == AccA);
  assign unusedWdata = ^busWdata[31:2*AGENTS];

  always_comb begin
    strb = '0;
    if (busWrite && isArb) begin
      strb.setMask[AGENTS-1:0] = busWdata[0 +: AGENTS];
      strb.clrMask[AGENTS-1:0] = busWdata[AGENTS +: AGENTS];
    end
    strb.accWr   = busWrite && isAcc;
    strb.accData = busWdata[1:0];
    strb.extWr   = busWrite && !isArb && !isAcc && accEn;
    strb.readSel = isArb ? RD_ARB : (isAcc ? RD_ACC : RD_NONE);
  end

  // R9: the gated strobe never fires while access is disabled
  a_r9_gate_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    strb.extWr |-> accEn);
  // R9: the arbitration and access words never raise the gated strobe
  a_r9_local_not_gated: assert property (@(posedge clk) disable iff (!rstN)
    (isArb || isAcc) |-> !strb.extWr);
endmodule

// File: rtl/mlk_datapath.sv
module mlk_datapath
  import mlk_pkg::*;
#(
  parameter int AGENTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              globalWrEn,
  output logic [31:0]       rdata,
  output logic [AGENTS-1:0] grant,
  output logic              accEn,
  output logic              wrPermit
);
  localparam int GRANT_LSB = 2 * AGENTS;
  localparam int REQ_LSB   = 3 * AGENTS;

  logic [AGENTS-1:0] reqQ, reqD, grantQ, grantD, pick;
  logic [AGENTS-1:0] setM, clrM;
  logic [1:0]        accQ;
  logic              unusedHi;

  assign setM = strb.setMask[AGENTS-1:0];
  assign clrM = strb.clrMask[AGENTS-1:0];
  assign unusedHi = ^{strb.setMask[MAX_AGENTS-1:AGENTS], strb.clrMask[MAX_AGENTS-1:AGENTS]};

  // clear beats set for the same request
  assign reqD = (reqQ | setM) & ~clrM;

  // lowest index wins: scan high to low so the last hit is the winner
  always_comb begin
    pick = '0;
    for (int i = AGENTS - 1; i >= 0; i--) begin
      if (reqD[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  // non-preemptive: keep the current owner while its request survives
  assign grantD = ((grantQ & reqD) != '0) ? grantQ : pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ   <= '0;
      grantQ <= '0;
      accQ   <= '0;
    end else begin
      reqQ   <= reqD;
      grantQ <= grantD;
      if (strb.accWr) accQ <= strb.accData;
    end
  end

  always_comb begin
    rdata = '0;
    case (strb.readSel)
      RD_ARB: begin
        rdata[GRANT_LSB +: AGENTS] = grantQ;
        rdata[REQ_LSB +: AGENTS]   = reqQ;
      end
      RD_ACC:  rdata[1:0] = accQ;
      default: rdata = '0;
    endcase
  end

  assign grant    = grantQ;
  assign accEn    = accQ[0];
  assign wrPermit = globalWrEn | accQ[1];

  // R4: never more than one owner
  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));
  // R6: the owner stays unless its own clear strobe arrives
  a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    ((grantQ != '0) && ((grantQ & clrM) == '0)) |=> (grantQ == $past(grantQ)));
  // R7: pending work always has an owner
  a_r7_no_idle_lock: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ != '0) |-> (grantQ != '0));
  // R7: an owner always has a live request
  a_r7_owner_requests: assert property (@(posedge clk) disable iff (!rstN)
    ((grantQ & ~reqQ) == '0));
  // R8: a clear strobe always leaves its request low
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (clrM != '0) |=> ((reqQ & $past(clrM)) == '0));
endmodule

// File: rtl/mem_lock_arb.sv
module mem_lock_arb
  import mlk_pkg::*;
#(
  parameter int AGENTS   = 4,
  parameter int ADDR_W   = 4,
  parameter int ARB_ADDR = 0,
  parameter int ACC_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              globalWrEn,
  output logic [AGENTS-1:0] grantOneHot,
  output logic              writePermit,
  output logic              extRegWrite
);
  ctrlStrobes_t strb;
  logic         accEn;

  mlk_ctrl #(
    .AGENTS(AGENTS), .ADDR_W(ADDR_W), .ARB_ADDR(ARB_ADDR), .ACC_ADDR(ACC_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .accEn(accEn), .strb(strb)
  );

  mlk_datapath #(.AGENTS(AGENTS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .globalWrEn(globalWrEn),
    .rdata(busRdata), .grant(grantOneHot), .accEn(accEn), .wrPermit(writePermit)
  );

  assign extRegWrite = strb.extWr;
endmodule

// File: tb/mem_lock_arb_test.sv
module mem_lock_arb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'd0;
  logic [31:0] busWdata = '0;
  logic        globalWrEn = 1'b0;
  logic [31:0] busRdata;
  logic [3:0]  grantOneHot;
  logic        writePermit, extRegWrite;

  int checks = 0;
  int fails = 0;

  // reference state
  bit [3:0] mReq = '0;
  int       mOwner = -1;
  bit [1:0] mAcc = '0;

  always #2 clk = ~clk;

  mem_lock_arb uut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .globalWrEn(globalWrEn),
    .grantOneHot(grantOneHot), .writePermit(writePermit), .extRegWrite(extRegWrite)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] mGrant();
    logic [3:0] g = '0;
    if (mOwner >= 0) g[mOwner] = 1'b1;
    return g;
  endfunction

  function automatic logic [31:0] mRead(logic [3:0] a);
    logic [31:0] r = '0;
    if (a == 4'd0) begin
      r[11:8]  = mGrant();
      r[15:12] = mReq;
    end else if (a == 4'd1) r[1:0] = mAcc;
    return r;
  endfunction

  // behavioural model: request set, owner index, access bits
  always @(posedge clk) begin
    if (!rstN) begin
      mReq = '0; mOwner = -1; mAcc = '0;
    end else if (busWrite) begin
      if (busAddr == 4'd0) begin
        for (int n = 0; n < 4; n++) begin
          if (busWdata[n]) mReq[n] = 1'b1;
          if (busWdata[4+n]) mReq[n] = 1'b0;
        end
        if (mOwner < 0 || !mReq[mOwner]) begin
          mOwner = -1;
          for (int n = 3; n >= 0; n--) if (mReq[n]) mOwner = n;
        end
      end else if (busAddr == 4'd1) mAcc = busWdata[1:0];
    end
  end

  // every-cycle comparison, away from both edges
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      chk("R4 R6 grant output", {28'd0, grantOneHot}, {28'd0, mGrant()});
      chk("R3 readback", busRdata, mRead(busAddr));
      chk("R10 write permit", {31'd0, writePermit}, {31'd0, globalWrEn | mAcc[1]});
      chk("R9 gated write", {31'd0, extRegWrite},
          {31'd0, busWrite && busAddr > 4'd1 && mAcc[0]});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 4'd0; busWdata = '0;
  endtask

  task automatic rdArb(string tag, logic [31:0] exp);
    @(negedge clk);
    busAddr = 4'd0;
    #1 chk(tag, busRdata, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    rdArb("R3 reset state", 32'h0);
    chk("R3 reset grant", {28'd0, grantOneHot}, 32'h0);

    wr(4'd0, 32'h0);
    rdArb("R1 zero write no effect", 32'h0);
    wr(4'd0, 32'h4);
    rdArb("R5 free lock granted to agent 2", 32'h4400);
    wr(4'd0, 32'h3);
    rdArb("R6 owner 2 kept against 0 and 1", 32'h7400);
    wr(4'd0, 32'h40);
    rdArb("R7 handoff to agent 0", 32'h3100);
    wr(4'd0, 32'h88);
    rdArb("R8 clear beats set for agent 3", 32'h3100);
    wr(4'd0, 32'h10);
    rdArb("R7 handoff to agent 1", 32'h2200);
    wr(4'd0, 32'h20);
    rdArb("R2 clear releases last request", 32'h0);

    // access control
    @(negedge clk);
    busWrite = 1'b1; busAddr = 4'd5; busWdata = 32'h1;
    #1 chk("R9 gated while disabled", {31'd0, extRegWrite}, 32'h0);
    @(negedge clk) busWrite = 1'b0;
    wr(4'd1, 32'hFFFF_FFFD);
    @(negedge clk);
    busAddr = 4'd1;
    #1 chk("R11 access readback", busRdata, 32'h1);
    chk("R10 permit off", {31'd0, writePermit}, 32'h0);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 4'd7; busWdata = 32'h0;
    #1 chk("R9 passed while enabled", {31'd0, extRegWrite}, 32'h1);
    chk("R11 other address reads 0", busRdata, 32'h0);
    @(negedge clk) busWrite = 1'b0;
    globalWrEn = 1'b1;
    #1 chk("R10 global enable alone", {31'd0, writePermit}, 32'h1);
    globalWrEn = 1'b0;
    wr(4'd1, 32'h2);
    #1 chk("R10 override bit", {31'd0, writePermit}, 32'h1);
    wr(4'd0, 32'h8);
    rdArb("R9 arbitration write with access off", 32'h8800);
    wr(4'd0, 32'h80);

    // random arbitration traffic checked by the model
    for (int k = 0; k < 400; k++) begin
      wr(($urandom_range(0, 5) == 0) ? 4'd1 : 4'd0, {24'd0, 8'($urandom)});
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule